// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped master for IEEE Clause 22 management frames on an MDC/MDIO pair. A processor reaches it through a simple 32-bit register port with a byte address and a write strobe. Read data is returned combinationally for the addressed register. To start a transaction, software writes one command word. That word holds the register number, the PHY address, the start-of-frame and opcode fields, and a start flag. The block then sends a 32-bit preamble and the frame, MSB first. MDC is the system clock divided by a parameterised ratio.

The start flag also serves as the busy indication. It reads back as 1 while a frame is on the wire and drops to 0 once the frame is complete. For a write, software must load the 16-bit payload into the write-data register before it writes the command word. For a read, the block releases the line during turnaround and checks that the PHY pulls the second turnaround bit low. It then shifts in 16 data bits. If no PHY answers, a sticky failure bit is set in the status register and the read-data register keeps its old value.

MDIO is presented as three pins: output value, output enable and input. A pull-up on the board is assumed. Between frames, MDC rests high and the output enable is off.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset, and whenever no frame is in progress, MDC is high and the MDIO output enable is low. After reset, the command (0x00), status (0x10) and read-data (0x0C) registers read as zero.
- R2: The command word at offset 0x00 has these fields:
  - bit 14: start flag;
  - bits 13:12: start-of-frame field;
  - bits 11:10: opcode;
  - bits 9:5: PHY address;
  - bits 4:0: register number.
  
  Writing the word with bit 14 set launches a frame. Bit 14 then reads back as 1 from the next cycle until the frame ends, and as 0 afterwards.
- R3: Each frame is 64 bits on MDIO, MSB first:
  - 32 ones;
  - command bits 13:12 as written;
  - command bits 11:10 as written;
  - command bits 9:5;
  - command bits 4:0;
  - two turnaround bits;
  - 16 data bits.
  
  For a non-read opcode, the turnaround bits are 1 then 0, the data is the low 16 bits of the write-data register (offset 0x08), and all 64 bits are driven.
- R4: One MDC period spans 2*CLK_DIV_HALF system clocks. MDIO output changes only after a falling MDC edge, and MDIO input is sampled at the rising edge.
- R5: For opcode 10 (read), the output enable is off from the first turnaround bit to the end of the frame, so exactly 46 bits are driven. When the second turnaround bit is sampled as 0, the 16 sampled data bits, first one in bit 15, appear in bits 15:0 of the read-data register (offset 0x0C).
- R6: If the second turnaround bit of a read is sampled as 1, bit 1 of the status register (offset 0x10) is set and the read-data register is left unchanged.
- R7: The status failure bit stays set until the next read frame starts, and clears at that start.
- R8: A write to the command register while bit 14 reads as 1 is ignored: the stored fields are unchanged and no further frame is sent.
- R9: A command write with bit 14 clear stores bits 13:0, which read back, and sends no frame.
- R10: The address register at offset 0x04 stores all 32 written bits and reads them back. It has no effect on frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Byte address of the register accessed |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Read data of the addressed register (combinational) |
| mdc | output | 1 | Management clock, high at rest |
| mdioOut | output | 1 | MDIO value driven by the block |
| mdioOe | output | 1 | MDIO output enable |
| mdioIn | input | 1 | MDIO value seen on the line |

## Verification
The bench builds the block with CLK_DIV_HALF set to 2, so one MDC period is four system clocks and a full frame takes under 300 cycles. This keeps several complete write and read frames, an overlapping command, and three different PHY behaviours within a short run. The three PHY behaviours are a correct response, a silent line, and a high second turnaround bit. Because the half period is larger than one, the check that MDC holds for at least two consecutive clocks is active.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int FRAME_BITS = 64;
  localparam int POS_W      = $clog2(FRAME_BITS) + 1;
  localparam int TA_FIRST   = 46;
  localparam int TA_SECOND  = 47;
  localparam int DATA_FIRST = 48;

  localparam logic [4:0] OFS_CMD  = 5'h00;
  localparam logic [4:0] OFS_ADDR = 5'h04;
  localparam logic [4:0] OFS_WD   = 5'h08;
  localparam logic [4:0] OFS_RD   = 5'h0C;
  localparam logic [4:0] OFS_STAT = 5'h10;

  localparam logic [1:0] OP_READ  = 2'b10;

  typedef struct packed {
    logic             launch;
    logic             driveEdge;
    logic             sampleEdge;
    logic             finish;
    logic [POS_W-1:0] bitPos;
  } mdioStrobes_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV_HALF = 20
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         startReq,
  output logic         busy,
  output logic         mdc,
  output mdioStrobes_t strb
);
  localparam int DIV_W = (CLK_DIV_HALF > 1) ? $clog2(CLK_DIV_HALF) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV_HALF - 1);
  localparam logic [POS_W-1:0] POS_END  = POS_W'(FRAME_BITS);

  logic [DIV_W-1:0] divCnt;
  logic [POS_W-1:0] bitPos;
  logic             tick;
  logic             tail;

  assign tick = busy && (divCnt == DIV_LAST);
  assign tail = (bitPos == POS_END);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy   <= 1'b0;
      mdc    <= 1'b1;
      divCnt <= '0;
      bitPos <= '0;
    end else if (!busy) begin
      if (startReq) begin
        busy   <= 1'b1;
        divCnt <= '0;
        bitPos <= '0;
        mdc    <= 1'b1;
      end
    end else if (tick) begin
      divCnt <= '0;
      if (tail) begin
        busy <= 1'b0;
      end else begin
        mdc <= ~mdc;
        if (!mdc) bitPos <= bitPos + 1'b1;
      end
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  always_comb begin
    strb.launch     = startReq && !busy;
    strb.driveEdge  = tick && mdc && !tail;
    strb.sampleEdge = tick && !mdc;
    strb.finish     = tick && tail;
    strb.bitPos     = bitPos;
  end

  assert_mdc_idle_high_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> mdc);

  generate
    if (CLK_DIV_HALF > 1) begin : gHalfCheck
      assert_mdc_half_period_R4: assert property (@(posedge clk) disable iff (!rstN)
        (busy && !$stable(mdc)) |=> $stable(mdc));
    end
  endgenerate

  assert_frame_ends_R2: assert property (@(posedge clk) disable iff (!rstN)
    (busy && tail && tick) |=> (!busy && mdc));
endmodule

// File: rtl/mdio_dpath.sv
module mdio_dpath
  import mdio_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  mdioStrobes_t strb,
  input  logic         busy,
  input  logic         busWrEn,
  input  logic [4:0]   busAddr,
  input  logic [31:0]  busWrData,
  output logic [31:0]  busRdData,
  output logic         startReq,
  input  logic         mdioIn,
  output logic         mdioOut,
  output logic         mdioOe
);
  logic [13:0]           cmdReg;
  logic [31:0]           addrReg;
  logic [15:0]           wdReg;
  logic [15:0]           rdReg;
  logic                  failBit;
  logic [FRAME_BITS-1:0] shiftReg;
  logic [15:0]           rxShift;
  logic                  taOk;
  logic                  isRead;
  logic                  mdoReg;
  logic                  oeReg;
  logic                  cmdWr;
  logic                  readCmd;
  logic [FRAME_BITS-1:0] frameWord;

  assign cmdWr    = busWrEn && (busAddr == OFS_CMD);
  assign startReq = cmdWr && busWrData[14] && !busy;
  assign readCmd  = (busWrData[11:10] == OP_READ);
  assign frameWord = {32'hFFFF_FFFF, busWrData[13:0],
                      readCmd ? 2'b11 : 2'b10,
                      readCmd ? 16'hFFFF : wdReg};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg  <= '0;
      addrReg <= '0;
      wdReg   <= '0;
    end else if (busWrEn) begin
      if (busAddr == OFS_CMD && !busy) cmdReg <= busWrData[13:0];
      if (busAddr == OFS_ADDR)         addrReg <= busWrData;
      if (busAddr == OFS_WD)           wdReg <= busWrData[15:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '1;
      rxShift  <= '0;
      rdReg    <= '0;
      failBit  <= 1'b0;
      taOk     <= 1'b0;
      isRead   <= 1'b0;
      mdoReg   <= 1'b1;
      oeReg    <= 1'b0;
    end else begin
      if (strb.launch) begin
        shiftReg <= frameWord;
        isRead   <= readCmd;
        taOk     <= 1'b0;
        if (readCmd) failBit <= 1'b0;
      end
      if (strb.driveEdge) begin
        mdoReg   <= shiftReg[FRAME_BITS-1];
        shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b1};
        oeReg    <= !(isRead && strb.bitPos >= POS_W'(TA_FIRST));
      end
      if (strb.sampleEdge) begin
        if (isRead && strb.bitPos == POS_W'(TA_SECOND)) taOk <= !mdioIn;
        if (strb.bitPos >= POS_W'(DATA_FIRST)) rxShift <= {rxShift[14:0], mdioIn};
      end
      if (strb.finish) begin
        oeReg  <= 1'b0;
        mdoReg <= 1'b1;
        if (isRead) begin
          if (taOk) rdReg <= rxShift;
          else      failBit <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (busAddr)
      OFS_CMD:  busRdData = {17'b0, busy, cmdReg};
      OFS_ADDR: busRdData = addrReg;
      OFS_WD:   busRdData = {16'b0, wdReg};
      OFS_RD:   busRdData = {16'b0, rdReg};
      OFS_STAT: busRdData = {30'b0, failBit, 1'b0};
      default:  busRdData = '0;
    endcase
  end

  assign mdioOut = mdoReg;
  assign mdioOe  = oeReg;

  assert_oe_off_idle_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !mdioOe);

  assert_read_release_R5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isRead && strb.bitPos >= POS_W'(TA_SECOND)) |-> !mdioOe);

  assert_rddata_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failBit) |-> $stable(rdReg));

  assert_fail_clear_R7: assert property (@(posedge clk) disable iff (!rstN)
    (strb.launch && readCmd) |=> !failBit);

  assert_busy_ignore_R8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWr) |=> $stable(cmdReg));
endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV_HALF = 20
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [4:0]  busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData,
  output logic        mdc,
  output logic        mdioOut,
  output logic        mdioOe,
  input  logic        mdioIn
);
  mdioStrobes_t strb;
  logic         busy;
  logic         startReq;

  mdio_ctrl #(.CLK_DIV_HALF(CLK_DIV_HALF)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (startReq),
    .busy     (busy),
    .mdc      (mdc),
    .strb     (strb)
  );

  mdio_dpath uDpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busy      (busy),
    .busWrEn   (busWrEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .startReq  (startReq),
    .mdioIn    (mdioIn),
    .mdioOut   (mdioOut),
    .mdioOe    (mdioOe)
  );
endmodule

// File: tb/tb_mdio_mgmt_master.sv
module tb_mdio_mgmt_master;
  localparam int CLK_PERIOD = 10;
  localparam int DIV_HALF   = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [4:0]  busAddr = 5'h0;
  logic [31:0] busWrData = 32'h0;
  logic [31:0] busRdData;
  logic        mdc, mdioOut, mdioOe, mdioIn;

  int   total = 0;
  int   fails = 0;
  int   cycles = 0;

  // PHY model state
  int          phyMode = 0;  // 0 silent, 1 answers, 2 bad turnaround
  logic [15:0] phyData = 16'h0;
  logic        phyOe = 1'b0;
  logic        phyOut = 1'b1;
  int          fallCnt = 0;
  int          riseCnt = 0;
  int          oeRises = 0;
  logic [63:0] seen = 64'h0;
  longint      lastRise = 0;
  longint      period = 0;

  mdio_mgmt_master #(.CLK_DIV_HALF(DIV_HALF)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .mdc(mdc),
    .mdioOut(mdioOut), .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  assign mdioIn = mdioOe ? mdioOut : (phyOe ? phyOut : 1'b1);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) cycles++;

  always @(negedge mdc) begin
    if (phyMode != 0 && fallCnt == 46) phyOe = 1'b0;
    if (phyMode == 1 && fallCnt == 47) begin phyOe = 1'b1; phyOut = 1'b0; end
    if (phyMode == 2 && fallCnt == 47) begin phyOe = 1'b1; phyOut = 1'b1; end
    if (phyMode != 0 && fallCnt >= 48 && fallCnt <= 63) begin
      phyOe  = 1'b1;
      phyOut = phyData[63 - fallCnt];
    end
    fallCnt++;
  end

  always @(posedge mdc) begin
    seen = {seen[62:0], mdioIn};
    if (riseCnt > 0) period = $time - lastRise;
    lastRise = $time;
    if (mdioOe) oeRises++;
    riseCnt++;
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  task automatic phyPrep(input int mode, input logic [15:0] data);
    phyMode = mode; phyData = data; phyOe = 1'b0; phyOut = 1'b1;
    fallCnt = 0; riseCnt = 0; oeRises = 0; seen = 64'h0;
  endtask

  task automatic waitIdle();
    logic [31:0] v;
    for (int i = 0; i < 2000; i++) begin
      busRead(5'h00, v);
      if (!v[14]) break;
    end
    phyOe = 1'b0;
  endtask

  function automatic logic [31:0] mkCmd(input logic go, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] rg);
    return {17'b0, go, 2'b01, op, phy, rg};
  endfunction

  task automatic tReset();
    logic [31:0] v;
    chk("R1 mdc idle", 64'(mdc), 64'd1);
    chk("R1 oe idle", 64'(mdioOe), 64'd0);
    busRead(5'h00, v); chk("R1 cmd reset", 64'(v), 64'd0);
    busRead(5'h10, v); chk("R1 status reset", 64'(v), 64'd0);
    busRead(5'h0C, v); chk("R1 rdata reset", 64'(v), 64'd0);
  endtask

  task automatic tAddrReg();
    logic [31:0] v;
    busWrite(5'h04, 32'hDEAD_BEEF);
    busRead(5'h04, v); chk("R10 addr readback", 64'(v), 64'hDEAD_BEEF);
    chk("R10 no frame", 64'(mdc), 64'd1);
  endtask

  task automatic tNoStart();
    logic [31:0] v;
    phyPrep(0, 16'h0);
    busWrite(5'h00, mkCmd(1'b0, 2'b01, 5'd3, 5'd9));
    busRead(5'h00, v);
    chk("R9 fields stored", 64'(v), 64'(mkCmd(1'b0, 2'b01, 5'd3, 5'd9)));
    repeat (20) @(negedge clk);
    chk("R9 no mdc edges", 64'(riseCnt), 64'd0);
  endtask

  task automatic tWriteFrame();
    logic [31:0] v;
    logic [31:0] c;
    c = mkCmd(1'b1, 2'b01, 5'd5, 5'h12);
    phyPrep(0, 16'h0);
    busWrite(5'h08, 32'h0000_A5C3);
    busWrite(5'h00, c);
    busRead(5'h00, v); chk("R2 busy set", 64'(v[14]), 64'd1);
    waitIdle();
    busRead(5'h00, v); chk("R2 busy clear", 64'(v), 64'(c & 32'h3FFF));
    chk("R3 write frame bits", seen, {32'hFFFF_FFFF, c[13:0], 2'b10, 16'hA5C3});
    chk("R3 all bits driven", 64'(oeRises), 64'd64);
    chk("R4 mdc period", 64'(period), 64'(2 * DIV_HALF * CLK_PERIOD));
    chk("R1 idle after write", 64'({mdc, mdioOe}), 64'b10);
  endtask

  task automatic tReadOk(input logic [15:0] data, input string tag);
    logic [31:0] v;
    logic [31:0] c;
    c = mkCmd(1'b1, 2'b10, 5'd17, 5'd2);
    phyPrep(1, data);
    busWrite(5'h00, c);
    busRead(5'h10, v); chk({tag, " fail clear at start"}, 64'(v), 64'd0);
    waitIdle();
    busRead(5'h0C, v); chk({"R5 read data ", tag}, 64'(v), 64'(data));
    busRead(5'h10, v); chk({"R5 status ok ", tag}, 64'(v), 64'd0);
    chk("R5 driven bit count", 64'(oeRises), 64'd46);
    chk("R3 read frame bits", seen, {32'hFFFF_FFFF, c[13:0], 2'b10, data});
  endtask

  task automatic tReadFail(input int mode, input logic [15:0] keep);
    logic [31:0] v;
    phyPrep(mode, 16'h5A5A);
    busWrite(5'h00, mkCmd(1'b1, 2'b10, 5'd8, 5'd1));
    waitIdle();
    busRead(5'h10, v); chk("R6 fail bit set", 64'(v), 64'd2);
    busRead(5'h0C, v); chk("R6 rdata unchanged", 64'(v), 64'(keep));
    repeat (10) @(negedge clk);
    busRead(5'h10, v); chk("R7 fail sticky", 64'(v), 64'd2);
  endtask

  task automatic tBusyIgnore();
    logic [31:0] v;
    logic [31:0] a;
    a = mkCmd(1'b1, 2'b01, 5'd1, 5'd4);
    phyPrep(0, 16'h0);
    busWrite(5'h08, 32'h0000_1357);
    busWrite(5'h00, a);
    repeat (30) @(negedge clk);
    busWrite(5'h00, mkCmd(1'b1, 2'b10, 5'd30, 5'd31));
    busRead(5'h00, v); chk("R8 fields kept while busy", 64'(v), 64'(a));
    waitIdle();
    repeat (40) @(negedge clk);
    chk("R8 single frame", 64'(riseCnt), 64'd64);
    chk("R8 frame of first cmd", seen, {32'hFFFF_FFFF, a[13:0], 2'b10, 16'h1357});
    busRead(5'h00, v); chk("R8 fields after", 64'(v), 64'(a & 32'h3FFF));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tAddrReg();
    tNoStart();
    tWriteFrame();
    tReadOk(16'h1234, "R5a");
    tReadFail(0, 16'h1234);
    tReadOk(16'hC0DE, "R7");
    tReadFail(2, 16'hC0DE);
    tBusyIgnore();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    wait (cycles > 100000);
    total++;
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule